// File: doc/BRIEF.md
# SD Card Data Bus Engine

This block moves one data block at a time between a word-addressed buffer RAM and the four SD data lines. Each clock cycle is one bit period on the bus, so any clock division happens outside the block. A write pulse makes the engine read 32-bit words from the RAM and send them as a framed block. The frame is a zero start bit, the data, a CRC16 for each active line and a one end bit. If busy checking was requested, the engine then reads the card's CRC status token on DAT0 and reports the card's busy period. A read pulse arms the receiver. It waits for the start bit, packs the incoming bits into words, writes them to the RAM unless writeback is disabled, and checks the per-line CRCs and the end bit.

The bus-width input chooses 1-bit operation (DAT0 only) or 4-bit operation (all four lines). A capability-read mode takes in a short status block instead of a data block. In that mode nothing is written to the RAM. Instead, selected bits are pulled out as they arrive: bit 50 of a 64-bit card configuration block, or bit 401 and the 4-bit field at bits 379..376 of a 512-bit switch-function status block.

The RAM read port is asynchronous: `ram_rdata_i` must show the word at `ram_addr_o` in the same cycle. All mode inputs are sampled only in the cycle in which a start pulse is accepted.

Top module: `sd_dat_engine`

## Requirements
- R1: After reset no data line is driven (`dat_oe_o` = 0). `ack_o`, `busy_o`, `rx_active_o`, `valid_o`, `err_o`, `ram_we_o`, `wide_cap_o`, `hs_cap_o` and `fg1_res_o` are all 0.
- R2: A write drives only the active lanes (mask 0x1 in 1-bit mode, 0xF in 4-bit mode). It sends one cycle of 0, then the 4096 data bits, then one cycle of 1. Words go in address order 0..127, and each word goes out MSB first. In 4-bit mode each cycle carries a nibble, with word bit 31 on DAT3 in the first cycle.
- R3: Right after the data, each active lane sends its own 16-bit CRC (polynomial 0x1021, zero seed, computed over that lane's data bits), MSB first.
- R4: `ack_o` is a one-cycle pulse in the cycle after the end bit, and the bus is released at that point.
- R5: With busy checking on, the engine reads a token on DAT0: a 0, three status bits MSB first, then a 1. `wr_ok_o` becomes 1 when the status is 010, and 0 for any other status.
- R6: With busy checking on, `busy_o` is high in the cycles after the token in which DAT0 is low, and the engine returns to idle once DAT0 is high. `busy_o` stays 0 during the token, and at all times when busy checking is off.
- R7: A read waits until all active lanes are 0. Received bits are then packed into words with the same bit-to-lane mapping as R2 and written to addresses 0..127, with exactly 128 write strobes per block.
- R8: `rx_active_o` is high from the first data bit through the end-bit cycle, and low before and after.
- R9: In the cycle after the end bit, `valid_o` pulses if every active lane's CRC matches and the end bit is 1. Otherwise `err_o` pulses. The two are never high together.
- R10: With writeback disabled, a read performs no RAM writes but still reports `valid_o`/`err_o`.
- R11: A capability read with selection 0 receives 64 bits, writes no RAM, and sets `wide_cap_o` to stream bit 50. Bits are numbered 63 down to 0 in arrival order. Outside capability reads `wide_cap_o` holds its value.
- R12: A capability read with selection 1 receives 512 bits, numbered 511 down to 0. It sets `hs_cap_o` to bit 401 and `fg1_res_o` to bits 379..376, where 0x1 means the switch succeeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus4_i | input | 1 | 1 = 4-bit bus, 0 = DAT0 only |
| capmode_i | input | 1 | 1 = capability read instead of a data block |
| capsel_i | input | 1 | Capability block: 0 = configuration (64 bits), 1 = switch status (512 bits) |
| chkbusy_i | input | 1 | Read status token and report busy after a write |
| nowb_i | input | 1 | Suppress RAM writes on reads |
| wr_start_i | input | 1 | Start sending a block |
| rd_start_i | input | 1 | Arm reception of a block |
| ram_addr_o | output | 7 | Buffer RAM word address |
| ram_rdata_i | input | 32 | RAM word at `ram_addr_o` (asynchronous read) |
| ram_we_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 32 | RAM write word |
| dat_i | input | 4 | Sampled data lines |
| dat_o | output | 4 | Driven data line values |
| dat_oe_o | output | 4 | Per-line output enable |
| ack_o | output | 1 | Block sent pulse |
| wr_ok_o | output | 1 | Last status token was the accepted code |
| busy_o | output | 1 | Card holding DAT0 low after a write |
| rx_active_o | output | 1 | Reception in progress |
| valid_o | output | 1 | Block received correctly pulse |
| err_o | output | 1 | Block received with CRC or end-bit error pulse |
| wide_cap_o | output | 1 | Captured 4-bit bus capability bit |
| hs_cap_o | output | 1 | Captured high-speed support bit |
| fg1_res_o | output | 4 | Captured function group 1 result |

## Verification
The bench replays the bit-to-lane mapping in both widths. A design that swaps nibble order or lane numbering fails the data and CRC comparison on the first word. A receive CRC corrupted in a single bit must give `err_o` and not `valid_o`. A design that checks only the end bit, or checks the wrong lane, would report a good block. Status tokens with the accepted code and with a rejected code are both sent. The token's own low bits must not show up as busy, and DAT0 going low while busy checking is off must not show up either. Capability reads are run with the target bits both set and clear, so a design that is off by one in bit position, or that leaves a stale value, captures the wrong value. Writeback suppression is checked by counting write strobes.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_TX_SB, ST_TX_DAT, ST_TX_CRC, ST_TX_EB,
    ST_TOK_WAIT, ST_TOK, ST_TOK_EB, ST_BUSY,
    ST_RX_WAIT, ST_RX_DAT, ST_RX_CRC, ST_RX_EB
  } sdd_state_e;

  localparam logic [15:0] CRC16_POLY = 16'h1021;
  localparam logic [2:0]  TOK_ACCEPT = 3'b010;
endpackage

// File: rtl/sdd_crc_lane.sv
module sdd_crc_lane
  import sdd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        calc_i,
  input  logic        shift_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_d;
  logic        fb;
  logic        upd;

  always_comb begin
    fb    = crc_q[15] ^ bit_i;
    upd   = clr_i | calc_i | shift_i;
    crc_d = crc_q;
    if (clr_i)        crc_d = '0;
    else if (calc_i)  crc_d = {crc_q[14:0], 1'b0} ^ (fb ? CRC16_POLY : 16'h0000);
    else if (shift_i) crc_d = {crc_q[14:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (upd) crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  // R3
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_o == 16'h0000));
endmodule

// File: rtl/sdd_cap_decode.sv
module sdd_cap_decode #(
  parameter int CNT_W        = 13,
  parameter int SCR_WIDE_POS = 50,
  parameter int SWF_HS_POS   = 401,
  parameter int SWF_FG1_LSB  = 376
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             sel_i,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic [3:0]       bits_i,
  output logic             wide_cap_o,
  output logic             hs_cap_o,
  output logic [3:0]       fg1_o
);
  logic             wide_q, wide_d, hs_q, hs_d;
  logic [3:0]       fg_q, fg_d;
  logic [CNT_W-1:0] pos;

  always_comb begin
    wide_d = wide_q;
    hs_d   = hs_q;
    fg_d   = fg_q;
    pos    = '0;
    for (int k = 0; k < 4; k++) begin
      pos = idx_i - (wide_i ? CNT_W'(3 - k) : CNT_W'(0));
      if (wide_i || (k == 0)) begin
        if (!sel_i && (pos == CNT_W'(SCR_WIDE_POS))) wide_d = bits_i[k];
        if (sel_i && (pos == CNT_W'(SWF_HS_POS)))    hs_d   = bits_i[k];
        for (int j = 0; j < 4; j++)
          if (sel_i && (pos == CNT_W'(SWF_FG1_LSB + j))) fg_d[j] = bits_i[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      hs_q   <= 1'b0;
      fg_q   <= 4'h0;
    end else if (en_i) begin
      wide_q <= wide_d;
      hs_q   <= hs_d;
      fg_q   <= fg_d;
    end
  end

  assign wide_cap_o = wide_q;
  assign hs_cap_o   = hs_q;
  assign fg1_o      = fg_q;

  // R11 R12
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(wide_cap_o) && $stable(hs_cap_o) && $stable(fg1_o)));
endmodule

// File: rtl/sd_dat_engine.sv
module sd_dat_engine
  import sdd_pkg::*;
#(
  parameter int BLOCK_WORDS  = 128,
  parameter int SCR_BITS     = 64,
  parameter int SWF_BITS     = 512,
  parameter int SCR_WIDE_POS = 50,
  parameter int SWF_HS_POS   = 401,
  parameter int SWF_FG1_LSB  = 376,
  localparam int ADDR_W      = $clog2(BLOCK_WORDS),
  localparam int BLK_BITS    = BLOCK_WORDS * 32,
  localparam int CNT_W       = $clog2(BLK_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus4_i,
  input  logic              capmode_i,
  input  logic              capsel_i,
  input  logic              chkbusy_i,
  input  logic              nowb_i,
  input  logic              wr_start_i,
  input  logic              rd_start_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [31:0]       ram_rdata_i,
  output logic              ram_we_o,
  output logic [31:0]       ram_wdata_o,
  input  logic [3:0]        dat_i,
  output logic [3:0]        dat_o,
  output logic [3:0]        dat_oe_o,
  output logic              ack_o,
  output logic              wr_ok_o,
  output logic              busy_o,
  output logic              rx_active_o,
  output logic              valid_o,
  output logic              err_o,
  output logic              wide_cap_o,
  output logic              hs_cap_o,
  output logic [3:0]        fg1_res_o
);
  sdd_state_e        state_q, state_d;
  logic              bus4_q, bus4_d, cap_q, cap_d, sel_q, sel_d;
  logic              chk_q, chk_d, nowb_q, nowb_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_rem, lane_n;
  logic [3:0]        crcc_q, crcc_d, mask;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [31:0]       sh_q, sh_d, wdata_q, wdata_d;
  logic              we_q, we_d, ack_q, ack_d, valid_q, valid_d, err_q, err_d;
  logic [2:0]        tok_q, tok_d;
  logic              wrok_q, wrok_d;
  logic              word_done, crc_ok, tx_phase;
  logic              crc_clr, crc_calc, crc_shift;
  logic [3:0]        lane_bit;
  logic [15:0]       crc_w [4];

  assign lane_n    = bus4_q ? CNT_W'(4) : CNT_W'(1);
  assign mask      = bus4_q ? 4'hF : 4'h1;
  assign cnt_rem   = cnt_q - lane_n;
  assign word_done = (cnt_rem[4:0] == 5'd0);
  assign tx_phase  = (state_q == ST_TX_DAT);
  assign crc_clr   = (state_q == ST_IDLE);
  assign crc_calc  = tx_phase || (state_q == ST_RX_DAT) || (state_q == ST_RX_CRC);
  assign crc_shift = (state_q == ST_TX_CRC);

  // Per-lane CRC generators / checkers
  for (genvar k = 0; k < 4; k++) begin : g_crc
    sdd_crc_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (crc_clr),
      .calc_i  (crc_calc),
      .shift_i (crc_shift),
      .bit_i   (lane_bit[k]),
      .crc_o   (crc_w[k])
    );
  end

  // Line drive
  always_comb begin
    dat_o    = 4'hF;
    dat_oe_o = 4'h0;
    case (state_q)
      ST_TX_SB:  begin dat_o = 4'h0; dat_oe_o = mask; end
      ST_TX_DAT: begin
        dat_o    = bus4_q ? sh_q[31:28] : {3'b111, sh_q[31]};
        dat_oe_o = mask;
      end
      ST_TX_CRC: begin
        dat_o    = bus4_q ? {crc_w[3][15], crc_w[2][15], crc_w[1][15], crc_w[0][15]}
                          : {3'b111, crc_w[0][15]};
        dat_oe_o = mask;
      end
      ST_TX_EB:  begin dat_o = 4'hF; dat_oe_o = mask; end
      default: ;
    endcase
  end

  always_comb begin
    crc_ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      lane_bit[k] = tx_phase ? dat_o[k] : dat_i[k];
      if ((k == 0) || bus4_q) crc_ok = crc_ok && (crc_w[k] == 16'h0000);
    end
  end

  // Next state
  always_comb begin
    state_d = state_q;
    bus4_d  = bus4_q;  cap_d = cap_q;  sel_d = sel_q;
    chk_d   = chk_q;   nowb_d = nowb_q;
    cnt_d   = cnt_q;   crcc_d = crcc_q;
    addr_d  = we_q ? addr_q + ADDR_W'(1) : addr_q;
    sh_d    = sh_q;    wdata_d = wdata_q;
    we_d    = 1'b0;    ack_d = 1'b0;  valid_d = 1'b0;  err_d = 1'b0;
    tok_d   = tok_q;   wrok_d = wrok_q;
    case (state_q)
      ST_IDLE: begin
        addr_d = '0;
        if (wr_start_i) begin
          bus4_d  = bus4_i;
          chk_d   = chkbusy_i;
          sh_d    = ram_rdata_i;
          addr_d  = ADDR_W'(1);
          cnt_d   = CNT_W'(BLK_BITS);
          state_d = ST_TX_SB;
        end else if (rd_start_i) begin
          bus4_d  = bus4_i;
          cap_d   = capmode_i;
          sel_d   = capsel_i;
          nowb_d  = nowb_i;
          cnt_d   = capmode_i ? (capsel_i ? CNT_W'(SWF_BITS) : CNT_W'(SCR_BITS))
                              : CNT_W'(BLK_BITS);
          state_d = ST_RX_WAIT;
        end
      end
      ST_TX_SB: state_d = ST_TX_DAT;
      ST_TX_DAT: begin
        cnt_d = cnt_rem;
        sh_d  = bus4_q ? {sh_q[27:0], 4'h0} : {sh_q[30:0], 1'b0};
        if (word_done) begin
          sh_d   = ram_rdata_i;
          addr_d = addr_q + ADDR_W'(1);
        end
        if (cnt_rem == '0) begin
          state_d = ST_TX_CRC;
          crcc_d  = 4'd15;
        end
      end
      ST_TX_CRC: begin
        crcc_d = crcc_q - 4'd1;
        if (crcc_q == 4'd0) state_d = ST_TX_EB;
      end
      ST_TX_EB: begin
        ack_d   = 1'b1;
        state_d = chk_q ? ST_TOK_WAIT : ST_IDLE;
      end
      ST_TOK_WAIT: if (!dat_i[0]) begin
        state_d = ST_TOK;
        crcc_d  = 4'd2;
      end
      ST_TOK: begin
        tok_d  = {tok_q[1:0], dat_i[0]};
        crcc_d = crcc_q - 4'd1;
        if (crcc_q == 4'd0) begin
          state_d = ST_TOK_EB;
          wrok_d  = ({tok_q[1:0], dat_i[0]} == TOK_ACCEPT);
        end
      end
      ST_TOK_EB: state_d = ST_BUSY;
      ST_BUSY:   if (dat_i[0]) state_d = ST_IDLE;
      ST_RX_WAIT: if ((dat_i & mask) == 4'h0) state_d = ST_RX_DAT;
      ST_RX_DAT: begin
        cnt_d = cnt_rem;
        sh_d  = bus4_q ? {sh_q[27:0], dat_i} : {sh_q[30:0], dat_i[0]};
        if (word_done && !cap_q && !nowb_q) begin
          we_d    = 1'b1;
          wdata_d = sh_d;
        end
        if (cnt_rem == '0) begin
          state_d = ST_RX_CRC;
          crcc_d  = 4'd15;
        end
      end
      ST_RX_CRC: begin
        crcc_d = crcc_q - 4'd1;
        if (crcc_q == 4'd0) state_d = ST_RX_EB;
      end
      ST_RX_EB: begin
        if (crc_ok && ((dat_i & mask) == mask)) valid_d = 1'b1;
        else                                    err_d   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bus4_q  <= 1'b0;  cap_q <= 1'b0;  sel_q <= 1'b0;
      chk_q   <= 1'b0;  nowb_q <= 1'b0;
      cnt_q   <= '0;    crcc_q <= '0;   addr_q <= '0;
      sh_q    <= '0;    wdata_q <= '0;
      we_q    <= 1'b0;  ack_q <= 1'b0;  valid_q <= 1'b0;  err_q <= 1'b0;
      tok_q   <= '0;    wrok_q <= 1'b0;
    end else begin
      state_q <= state_d;
      bus4_q  <= bus4_d;  cap_q <= cap_d;  sel_q <= sel_d;
      chk_q   <= chk_d;   nowb_q <= nowb_d;
      cnt_q   <= cnt_d;   crcc_q <= crcc_d; addr_q <= addr_d;
      sh_q    <= sh_d;    wdata_q <= wdata_d;
      we_q    <= we_d;    ack_q <= ack_d;  valid_q <= valid_d;  err_q <= err_d;
      tok_q   <= tok_d;   wrok_q <= wrok_d;
    end
  end

  sdd_cap_decode #(
    .CNT_W        (CNT_W),
    .SCR_WIDE_POS (SCR_WIDE_POS),
    .SWF_HS_POS   (SWF_HS_POS),
    .SWF_FG1_LSB  (SWF_FG1_LSB)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       ((state_q == ST_RX_DAT) && cap_q),
    .sel_i      (sel_q),
    .wide_i     (bus4_q),
    .idx_i      (cnt_q - CNT_W'(1)),
    .bits_i     (dat_i),
    .wide_cap_o (wide_cap_o),
    .hs_cap_o   (hs_cap_o),
    .fg1_o      (fg1_res_o)
  );

  assign ram_addr_o  = addr_q;
  assign ram_we_o    = we_q;
  assign ram_wdata_o = wdata_q;
  assign ack_o       = ack_q;
  assign wr_ok_o     = wrok_q;
  assign valid_o     = valid_q;
  assign err_o       = err_q;
  assign busy_o      = (state_q == ST_BUSY) && !dat_i[0];
  assign rx_active_o = (state_q == ST_RX_DAT) || (state_q == ST_RX_CRC) || (state_q == ST_RX_EB);

  // R2
  tx_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dat_oe_o) |-> $past(state_q == ST_IDLE));
  // R2
  oe_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dat_oe_o) && $past(|dat_oe_o)) |-> $stable(dat_oe_o));
  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ((dat_oe_o == 4'h0) ##1 !ack_o));
  // R6
  busy_quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ((dat_oe_o == 4'h0) && !rx_active_o));
  // R7
  we_in_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> rx_active_o);
  // R8
  rx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active_o) |-> $past(state_q == ST_RX_WAIT));
  // R9
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));
endmodule

// File: tb/test_sd_dat_engine.sv
module test_sd_dat_engine;
  localparam int WORDS = 128;
  localparam int BLK   = WORDS * 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus4, capmode, capsel, chkbusy, nowb, wr_start, rd_start;
  logic [6:0]  ram_addr;
  logic [31:0] ram_rdata, ram_wdata;
  logic        ram_we;
  logic [3:0]  dat_i, dat_o, dat_oe;
  logic        ack, wr_ok, busy, rx_active, valid, err, wide_cap, hs_cap;
  logic [3:0]  fg1;

  logic [31:0] txmem [WORDS];
  logic [31:0] rxmem [WORDS];
  int          nwr = 0;
  int          nvec = 0;
  int          nfail = 0;

  always #10 clk = ~clk;

  assign ram_rdata = txmem[ram_addr];
  always @(posedge clk) if (ram_we) begin
    rxmem[ram_addr] <= ram_wdata;
    nwr <= nwr + 1;
  end

  sd_dat_engine i_sd_dat_engine (
    .clk(clk), .rst_n(rst_n), .bus4_i(bus4), .capmode_i(capmode), .capsel_i(capsel),
    .chkbusy_i(chkbusy), .nowb_i(nowb), .wr_start_i(wr_start), .rd_start_i(rd_start),
    .ram_addr_o(ram_addr), .ram_rdata_i(ram_rdata), .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
    .dat_i(dat_i), .dat_o(dat_o), .dat_oe_o(dat_oe), .ack_o(ack), .wr_ok_o(wr_ok),
    .busy_o(busy), .rx_active_o(rx_active), .valid_o(valid), .err_o(err),
    .wide_cap_o(wide_cap), .hs_cap_o(hs_cap), .fg1_res_o(fg1)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  task automatic run_write(input bit b4, input bit chkb, input logic [2:0] st, input int blen);
    int L, bad;
    logic [3:0] m;
    logic [15:0] ec [4];
    L = b4 ? 4 : 1;
    m = b4 ? 4'hF : 4'h1;
    for (int k = 0; k < 4; k++) ec[k] = 16'h0;
    for (int i = 0; i < WORDS; i++) txmem[i] = $urandom;
    @(negedge clk); bus4 = b4; chkbusy = chkb; wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
    chk((dat_oe == m) && ((dat_o & m) == 4'h0), "R2", "start bit oe/dat", {dat_oe, dat_o}, {m, 4'h0});
    bad = 0;
    for (int c = 0; c < BLK / L; c++) begin
      @(negedge clk);
      for (int k = 0; k < L; k++) begin
        int g;
        logic eb;
        g  = L * c + (L - 1 - k);
        eb = txmem[g / 32][31 - (g % 32)];
        if ((dat_o[k] !== eb) || (dat_oe !== m)) bad++;
        ec[k] = crc_step(ec[k], eb);
      end
    end
    chk(bad == 0, "R2", "data bit mismatches", bad, 0);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      for (int k = 0; k < L; k++) if (dat_o[k] !== ec[k][15 - i]) bad++;
    end
    chk(bad == 0, "R3", "per-lane CRC16 mismatches", bad, 0);
    @(negedge clk);
    chk((dat_oe == m) && ((dat_o & m) == m), "R2", "end bit oe/dat", {dat_oe, dat_o}, {m, m});
    chk(ack == 1'b0, "R4", "ack during end bit", ack, 0);
    @(negedge clk);
    chk((ack == 1'b1) && (dat_oe == 4'h0), "R4", "ack after end bit / bus released", {ack, dat_oe}, {1'b1, 4'h0});
    if (chkb) begin
      bad = 0;
      dat_i[0] = 1'b0;
      @(negedge clk); chk(ack == 1'b0, "R4", "ack one cycle only", ack, 0);
      dat_i[0] = st[2]; #1 if (busy) bad++;
      @(negedge clk); dat_i[0] = st[1]; #1 if (busy) bad++;
      @(negedge clk); dat_i[0] = st[0]; #1 if (busy) bad++;
      @(negedge clk); dat_i[0] = 1'b1;
      chk(wr_ok == (st == 3'b010), "R5", "status token acceptance", wr_ok, (st == 3'b010));
      chk(bad == 0, "R6", "busy during token bits", bad, 0);
      bad = 0;
      for (int i = 0; i < blen; i++) begin
        @(negedge clk); dat_i[0] = 1'b0; #1 if (!busy) bad++;
      end
      chk(bad == 0, "R6", "busy missing while DAT0 low", bad, 0);
      @(negedge clk); dat_i[0] = 1'b1; #1
      chk(busy == 1'b0, "R6", "busy after DAT0 release", busy, 0);
      @(negedge clk);
    end else begin
      bad = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); dat_i[0] = 1'b0; #1 if (busy) bad++;
      end
      chk(bad == 0, "R6", "busy with checking off", bad, 0);
      @(negedge clk); dat_i[0] = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic run_read(input bit b4, input bit capm, input bit sel, input bit nowbk,
                          input bit corrupt, input logic [BLK-1:0] strm, input int tot);
    int L, bad, w0;
    logic [3:0] m, d;
    logic [15:0] ec [4];
    L  = b4 ? 4 : 1;
    m  = b4 ? 4'hF : 4'h1;
    w0 = nwr;
    for (int k = 0; k < 4; k++) ec[k] = 16'h0;
    @(negedge clk); bus4 = b4; capmode = capm; capsel = sel; nowb = nowbk; rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    chk(rx_active == 1'b0, "R8", "active before start bit", rx_active, 0);
    @(negedge clk); dat_i = ~m;
    bad = 0;
    for (int c = 0; c < tot / L; c++) begin
      @(negedge clk);
      d = 4'hF;
      for (int k = 0; k < L; k++) begin
        d[k]  = strm[tot - 1 - (L * c + (L - 1 - k))];
        ec[k] = crc_step(ec[k], d[k]);
      end
      dat_i = d;
      #1 if (!rx_active) bad++;
    end
    chk(bad == 0, "R8", "inactive during data", bad, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      d = 4'hF;
      for (int k = 0; k < L; k++) d[k] = ec[k][15 - i];
      if (corrupt && (i == 5)) d[0] = ~d[0];
      dat_i = d;
    end
    @(negedge clk); dat_i = 4'hF;
    chk((rx_active == 1'b1) && (valid == 1'b0), "R8", "end-bit cycle active", {rx_active, valid}, 2'b10);
    @(negedge clk);
    chk((valid == !corrupt) && (err == corrupt), "R9", "valid/err result", {valid, err}, {!corrupt, corrupt});
    chk(rx_active == 1'b0, "R8", "active after block", rx_active, 0);
    if (!capm && !nowbk) begin
      bad = 0;
      for (int w = 0; w < WORDS; w++) if (rxmem[w] !== strm[32 * (WORDS - 1 - w) +: 32]) bad++;
      chk(bad == 0, "R7", "RAM word mismatches", bad, 0);
      chk((nwr - w0) == WORDS, "R7", "write strobe count", nwr - w0, WORDS);
    end else if (nowbk) begin
      chk((nwr - w0) == 0, "R10", "writes with writeback off", nwr - w0, 0);
    end else begin
      chk((nwr - w0) == 0, "R11", "writes in capability read", nwr - w0, 0);
    end
    if (capm && !sel) chk(wide_cap == strm[50], "R11", "bus-width capability bit", wide_cap, strm[50]);
    if (capm && sel) begin
      chk(hs_cap == strm[401], "R12", "high-speed bit", hs_cap, strm[401]);
      chk(fg1 == strm[379:376], "R12", "function group 1 result", fg1, strm[379:376]);
    end
    @(negedge clk);
  endtask

  initial begin
    logic [BLK-1:0] s;
    logic           keep;
    void'($urandom(32'd5417));
    rst_n = 1'b0; bus4 = 0; capmode = 0; capsel = 0; chkbusy = 0; nowb = 0;
    wr_start = 0; rd_start = 0; dat_i = 4'hF;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk({dat_oe, ack, busy, rx_active, valid, err, ram_we, wide_cap, hs_cap, fg1} == '0,
            "R1", "reset outputs", {dat_oe, ack, busy, rx_active, valid, err, ram_we, wide_cap, hs_cap, fg1}, 0);
        run_write(1'b0, 1'b0, 3'b000, 0);
        run_write(1'b1, 1'b1, 3'b010, 5);
        run_write(1'b0, 1'b1, 3'b101, 3);
        for (int i = 0; i < BLK / 32; i++) s[i * 32 +: 32] = $urandom;
        run_read(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, s, BLK);
        for (int i = 0; i < BLK / 32; i++) s[i * 32 +: 32] = $urandom;
        run_read(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, s, BLK);
        run_read(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, s, BLK);
        run_read(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, s, BLK);
        s = '0; s[63:0] = {$urandom, $urandom}; s[50] = 1'b1;
        run_read(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, s, 64);
        s[50] = 1'b0;
        run_read(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, s, 64);
        s[50] = 1'b1;
        run_read(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, s, 64);
        keep = wide_cap;
        for (int i = 0; i < 16; i++) s[i * 32 +: 32] = $urandom;
        s[401] = 1'b1; s[379:376] = 4'h1;
        run_read(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, s, 512);
        chk(wide_cap == keep, "R11", "bus-width bit held over switch read", wide_cap, keep);
        s[401] = 1'b0; s[379:376] = 4'hA;
        run_read(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, s, 512);
        s[401] = 1'b1; s[379:376] = 4'h1;
        run_read(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, s, 512);
      end
      begin
        repeat (150000) @(posedge clk);
        nvec++; nfail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule